// File: doc/BRIEF.md
# Disk Controller Power-Up Self-Test Sequencer

This block runs on the host side of a shared byte-wide mailbox that sits between a host processor and a disk controller. After a start pulse it checks that the controller came out of reset in a usable state. It performs a fixed chain of checks, and stops at the first check that fails:

1. It waits, with a timeout, for the controller to raise its ready flag.
2. It reads the controller's startup status byte.
3. It runs a write and read-back test on one mailbox byte.
4. It posts the interrupt-disable command and waits for the controller to clear the command byte.

Every failure produces the same error code, 57 decimal. A separate two-bit stage output records which check failed, so that the fault can be traced. The mailbox port is a plain master port with no wait states. A read issued in one cycle returns its data on `memRdata` in the following cycle.

Top module: `selftest_seq`

## Requirements
- R1: While reset is held and after it is released, `done`, `errFlag` and `memReq` are 0, and `errCode` reads 0.
- R2: After `start`, no mailbox access occurs until `devReady` is seen high. If `devReady` stays low for `READY_TIMEOUT` cycles, the run fails with stage 0, and `done` comes no earlier than `READY_TIMEOUT` cycles after `start`.
- R3: The first access is a read of mailbox byte 0x0B. A value other than 0x00 fails the run with stage 1. The only addresses the block ever reads are 0x00, 0x01 and 0x0B.
- R4: After a zero status, the block writes 0x55 to mailbox byte 0x01 and reads that byte back. Any value other than 0x55 fails the run with stage 2.
- R5: After a good loopback, the block writes `CMD_CODE` to mailbox byte 0x00. `CMD_CODE` must lie in 0x80..0x89, and every write to byte 0x00 carries a value in that range.
- R6: After the command write, the block polls byte 0x00. A read of 0x00 means the command was accepted and the run passes. If `CMD_TIMEOUT` cycles elapse first, the run fails with stage 3.
- R7: On any failure, `errFlag` is 1 and `errCode` is 57. On a pass, `errFlag` is 0 and `errCode` is 0.
- R8: `done` is high for exactly one cycle at the end of a run. `errFlag`, `errCode` and `errStage` change only at that point or when a new run starts, and they hold their values until the next `start`.
- R9: A failed check ends the run. No later check touches the mailbox, so a failure at stage 0, 1 or 2 leaves the command byte unwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when the block is idle |
| devReady | input | 1 | Controller ready flag |
| memReq | output | 1 | Mailbox access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Mailbox byte offset |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid the cycle after a read request |
| done | output | 1 | One-cycle end-of-run pulse |
| errFlag | output | 1 | 1 when the last run failed |
| errCode | output | 8 | 57 on failure, 0 otherwise |
| errStage | output | 2 | Failing check: 0 ready, 1 status, 2 loopback, 3 command |

## Verification
The bench builds the block with `READY_TIMEOUT` = 20, `CMD_TIMEOUT` = 16 and `CMD_CODE` = 0x85. With timeouts this small, a single run takes a few dozen cycles. That makes it practical to sweep every ready delay below the timeout, every one of the 256 status values, a stuck-high fault on each of the 8 loopback bits, and every command-clear delay the poll window accepts. It also exercises both timeouts to expiry. A behavioural mailbox model records when the block first touched the mailbox and whether it wrote the command byte, so the ordering rules and the stop-at-first-failure rule are checked on every run.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

  localparam logic [7:0] FAIL_CODE   = 8'd57;
  localparam logic [7:0] LOOP_VALUE  = 8'h55;
  localparam logic [7:0] OFS_CMD     = 8'h00;
  localparam logic [7:0] OFS_LOOP    = 8'h01;
  localparam logic [7:0] OFS_STATUS  = 8'h0B;

  typedef enum logic [1:0] {
    STG_READY  = 2'd0,
    STG_STATUS = 2'd1,
    STG_LOOP   = 2'd2,
    STG_CMD    = 2'd3
  } stage_e;

  typedef enum logic [1:0] {
    SEL_CMD    = 2'd0,
    SEL_LOOP   = 2'd1,
    SEL_STATUS = 2'd2
  } addrSel_e;

  typedef struct packed {
    logic     rd;
    logic     wr;
    addrSel_e addrSel;
    logic     cntClr;
    logic     clrErr;
    logic     setFail;
    stage_e   stage;
  } strobe_t;

endpackage

// File: rtl/selftest_ctrl.sv
module selftest_ctrl
  import selftest_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    devReady,
  input  logic    readyExpired,
  input  logic    cmdExpired,
  input  logic    rdZero,
  input  logic    rdPattern,
  output strobe_t stb,
  output logic    done
);

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_RDY, S_RD_STAT, S_CHK_STAT, S_WR_LOOP, S_RD_LOOP,
    S_CHK_LOOP, S_WR_CMD, S_POLL_RD, S_POLL_CHK, S_DONE
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    stb         = '0;
    stb.addrSel = SEL_CMD;
    stb.stage   = STG_READY;
    done        = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        stb.cntClr = 1'b1;
        stb.clrErr = 1'b1;
        stateNext  = S_WAIT_RDY;
      end
      S_WAIT_RDY: begin
        if (devReady) stateNext = S_RD_STAT;
        else if (readyExpired) begin
          stb.setFail = 1'b1;
          stb.stage   = STG_READY;
          stateNext   = S_DONE;
        end
      end
      S_RD_STAT: begin
        stb.rd      = 1'b1;
        stb.addrSel = SEL_STATUS;
        stateNext   = S_CHK_STAT;
      end
      S_CHK_STAT: begin
        if (rdZero) stateNext = S_WR_LOOP;
        else begin
          stb.setFail = 1'b1;
          stb.stage   = STG_STATUS;
          stateNext   = S_DONE;
        end
      end
      S_WR_LOOP: begin
        stb.wr      = 1'b1;
        stb.addrSel = SEL_LOOP;
        stateNext   = S_RD_LOOP;
      end
      S_RD_LOOP: begin
        stb.rd      = 1'b1;
        stb.addrSel = SEL_LOOP;
        stateNext   = S_CHK_LOOP;
      end
      S_CHK_LOOP: begin
        if (rdPattern) stateNext = S_WR_CMD;
        else begin
          stb.setFail = 1'b1;
          stb.stage   = STG_LOOP;
          stateNext   = S_DONE;
        end
      end
      S_WR_CMD: begin
        stb.wr      = 1'b1;
        stb.addrSel = SEL_CMD;
        stb.cntClr  = 1'b1;
        stateNext   = S_POLL_RD;
      end
      S_POLL_RD: begin
        stb.rd      = 1'b1;
        stb.addrSel = SEL_CMD;
        stateNext   = S_POLL_CHK;
      end
      S_POLL_CHK: begin
        if (rdZero) stateNext = S_DONE;
        else if (cmdExpired) begin
          stb.setFail = 1'b1;
          stb.stage   = STG_CMD;
          stateNext   = S_DONE;
        end else stateNext = S_POLL_RD;
      end
      S_DONE: begin
        done      = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/selftest_dp.sv
module selftest_dp
  import selftest_pkg::*;
#(
  parameter int unsigned ADDR_W        = 9,
  parameter int unsigned READY_TIMEOUT = 1_500_000_000,
  parameter int unsigned CMD_TIMEOUT   = 100_000,
  parameter logic [7:0]  CMD_CODE      = 8'h85
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              readyExpired,
  output logic              cmdExpired,
  output logic              rdZero,
  output logic              rdPattern,
  output logic              errFlag,
  output logic [7:0]        errCode,
  output logic [1:0]        errStage
);

  localparam int unsigned MAX_T = (READY_TIMEOUT > CMD_TIMEOUT) ? READY_TIMEOUT : CMD_TIMEOUT;
  localparam int unsigned CNT_W = $clog2(MAX_T) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] READY_LIM = CNT_W'(READY_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] CMD_LIM   = CNT_W'(CMD_TIMEOUT);

  logic [CNT_W-1:0] cycCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                 cycCnt <= '0;
    else if (stb.cntClr)       cycCnt <= '0;
    else if (cycCnt != CNT_MAX) cycCnt <= cycCnt + 1'b1;
  end

  assign readyExpired = (cycCnt == READY_LIM);
  assign cmdExpired   = (cycCnt >= CMD_LIM);
  assign rdZero       = (memRdata == 8'h00);
  assign rdPattern    = (memRdata == LOOP_VALUE);

  always_comb begin
    unique case (stb.addrSel)
      SEL_LOOP:   memAddr = ADDR_W'(OFS_LOOP);
      SEL_STATUS: memAddr = ADDR_W'(OFS_STATUS);
      default:    memAddr = ADDR_W'(OFS_CMD);
    endcase
  end

  assign memReq   = stb.rd | stb.wr;
  assign memWe    = stb.wr;
  assign memWdata = (stb.addrSel == SEL_LOOP) ? LOOP_VALUE : CMD_CODE;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrErr) begin
      errFlag  <= 1'b0;
      errStage <= 2'd0;
    end else if (stb.setFail) begin
      errFlag  <= 1'b1;
      errStage <= stb.stage;
    end
  end

  assign errCode = errFlag ? FAIL_CODE : 8'h00;

endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int unsigned ADDR_W        = 9,
  parameter int unsigned READY_TIMEOUT = 1_500_000_000,
  parameter int unsigned CMD_TIMEOUT   = 100_000,
  parameter logic [7:0]  CMD_CODE      = 8'h85
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              devReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              done,
  output logic              errFlag,
  output logic [7:0]        errCode,
  output logic [1:0]        errStage
);

  // R5: the command code must be one the controller accepts
  if (CMD_CODE < 8'h80 || CMD_CODE > 8'h89) begin : g_badCmd
    $error("CMD_CODE outside 0x80..0x89");
  end

  strobe_t stb;
  logic readyExpired, cmdExpired, rdZero, rdPattern;

  selftest_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .devReady(devReady),
    .readyExpired(readyExpired), .cmdExpired(cmdExpired),
    .rdZero(rdZero), .rdPattern(rdPattern), .stb(stb), .done(done)
  );

  selftest_dp #(
    .ADDR_W(ADDR_W), .READY_TIMEOUT(READY_TIMEOUT),
    .CMD_TIMEOUT(CMD_TIMEOUT), .CMD_CODE(CMD_CODE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .memRdata(memRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .readyExpired(readyExpired), .cmdExpired(cmdExpired),
    .rdZero(rdZero), .rdPattern(rdPattern),
    .errFlag(errFlag), .errCode(errCode), .errStage(errStage)
  );

endmodule

// File: rtl/selftest_chk.sv
module selftest_chk #(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              errFlag,
  input logic [7:0]        errCode,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memWdata
);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(errFlag) |-> (done || $past(start)));

  assert_fail_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && errFlag) |-> (errCode == 8'd57));

  assert_pass_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !errFlag) |-> (errCode == 8'd0));

  assert_loop_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAddr == ADDR_W'(1)) |-> (memWdata == 8'h55));

  assert_cmd_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAddr == ADDR_W'(0)) |-> (memWdata >= 8'h80 && memWdata <= 8'h89));

  assert_read_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> (memAddr == ADDR_W'(0) || memAddr == ADDR_W'(1) || memAddr == ADDR_W'(8'h0B)));

endmodule

bind selftest_seq selftest_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .errFlag(errFlag),
  .errCode(errCode), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata)
);

// File: tb/selftest_seq_tb.sv
module selftest_seq_tb_top;

  localparam int RT = 20;
  localparam int CT = 16;
  localparam logic [7:0] CMD = 8'h85;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic devReady = 1'b0;
  logic memReq, memWe, done, errFlag;
  logic [8:0] memAddr;
  logic [7:0] memWdata, errCode;
  logic [7:0] memRdata = 8'h00;
  logic [1:0] errStage;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  selftest_seq #(
    .ADDR_W(9), .READY_TIMEOUT(RT), .CMD_TIMEOUT(CT), .CMD_CODE(CMD)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .devReady(devReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .done(done), .errFlag(errFlag), .errCode(errCode),
    .errStage(errStage)
  );

  // Mailbox and controller model
  int         readyDelay;
  int         cmdDelay;
  logic [7:0] presetStatus;
  logic [7:0] stuckMask;
  logic [7:0] mem [16];
  int         sinceStart = 0;
  logic       cmdPend = 1'b0;
  int         cmdCnt = 0;
  logic       cmdSeen = 1'b0;
  logic [7:0] cmdVal = 8'h00;
  logic       earlyAccess = 1'b0;

  always @(posedge clk) begin
    if (start && rstN) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
      mem[11]     <= presetStatus;
      sinceStart  <= 0;
      cmdPend     <= 1'b0;
      cmdCnt      <= 0;
      cmdSeen     <= 1'b0;
      earlyAccess <= 1'b0;
    end else begin
      sinceStart <= sinceStart + 1;
      if (memReq && !devReady) earlyAccess <= 1'b1;
      if (memReq && memWe) begin
        mem[memAddr[3:0]] <= (memAddr == 9'd1) ? (memWdata | stuckMask) : memWdata;
        if (memAddr == 9'd0) begin
          cmdSeen <= 1'b1;
          cmdVal  <= memWdata;
          cmdPend <= (memWdata != 8'h00);
          cmdCnt  <= 0;
        end
      end else if (cmdPend) begin
        cmdCnt <= cmdCnt + 1;
        if (cmdDelay >= 0 && cmdCnt + 1 >= cmdDelay) begin
          mem[0]  <= 8'h00;
          cmdPend <= 1'b0;
        end
      end
      if (memReq && !memWe) memRdata <= mem[memAddr[3:0]];
    end
  end

  always @(negedge clk)
    devReady <= (readyDelay >= 0) && (sinceStart >= readyDelay);

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runCase(input int rd, input logic [7:0] st, input logic [7:0] mask, input int cd);
    int  expStage;
    logic expErr;
    int  waitCnt;
    int  lat;
    string tag;
    logic heldFlag;
    logic [1:0] heldStage;
    expErr = 1'b1;
    if (rd < 0)                          begin expStage = 0; tag = "R2"; end
    else if (st != 8'h00)                begin expStage = 1; tag = "R3"; end
    else if ((8'h55 | mask) != 8'h55)    begin expStage = 2; tag = "R4"; end
    else if (cd < 0)                     begin expStage = 3; tag = "R6"; end
    else begin expStage = 0; expErr = 1'b0; tag = "R6"; end
    readyDelay   = -1;
    presetStatus = st;
    stuckMask    = mask;
    cmdDelay     = cd;
    @(negedge clk);
    readyDelay = rd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitCnt = 0;
    while (!done && waitCnt < RT + 4 * CT + 50) begin
      @(negedge clk);
      waitCnt++;
    end
    lat = sinceStart;
    check(done == 1'b1, "R8 done seen", int'(done), 1);
    check(errFlag == expErr, tag, int'(errFlag), int'(expErr));
    check(errCode == (expErr ? 8'd57 : 8'd0), "R7", int'(errCode), expErr ? 57 : 0);
    if (expErr) check(errStage == 2'(expStage), tag, int'(errStage), expStage);
    if (rd < 0) check(lat >= RT, "R2 timeout length", lat, RT);
    check(earlyAccess == 1'b0, "R2 access before ready", int'(earlyAccess), 0);
    check(cmdSeen == (!expErr || expStage == 3), "R9 command write",
          int'(cmdSeen), int'(!expErr || expStage == 3));
    if (cmdSeen) check(cmdVal == CMD, "R5 command value", int'(cmdVal), int'(CMD));
    heldFlag  = errFlag;
    heldStage = errStage;
    @(negedge clk);
    check(done == 1'b0, "R8 pulse width", int'(done), 0);
    repeat (3) @(negedge clk);
    check(errFlag == heldFlag && errStage == heldStage, "R8 hold",
          int'({errFlag, errStage}), int'({heldFlag, heldStage}));
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    readyDelay = -1; cmdDelay = 0; presetStatus = 8'h00; stuckMask = 8'h00;
    repeat (4) @(negedge clk);
    check(done == 1'b0 && errFlag == 1'b0 && memReq == 1'b0 && errCode == 8'd0,
          "R1 in reset", int'({done, errFlag, memReq}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && errFlag == 1'b0 && memReq == 1'b0 && errCode == 8'd0,
          "R1 after reset", int'({done, errFlag, memReq}), 0);
    // R2: ready delays inside the window, then never ready
    for (int d = 0; d <= RT - 3; d++) runCase(d, 8'h00, 8'h00, 2);
    runCase(-1, 8'h00, 8'h00, 2);
    // R3: every startup status value
    for (int s = 0; s < 256; s++) runCase(1, 8'(s), 8'h00, 2);
    // R4: a stuck-high fault on each loopback bit
    for (int b = 0; b < 8; b++) runCase(0, 8'h00, 8'(1 << b), 2);
    // R6: command accepted after every delay in the window, then never
    for (int c = 0; c <= CT - 5; c++) runCase(0, 8'h00, 8'h00, c);
    runCase(0, 8'h00, 8'h00, -1);
    // R9: a failure followed by a clean run clears the error
    runCase(-1, 8'h00, 8'h00, 2);
    runCase(0, 8'h00, 8'h00, 3);
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

endmodule